// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command-path front end of an SD/MMC host controller. Software programs a 32-bit command argument as two 16-bit halves and then writes a 16-bit command word; that write launches the command toward a bit-serial command-line engine that lives outside the block. The command word carries the opcode together with the response class, a busy-wait hint, and the data-phase flags (data follows, read direction, multi-block). These flags are decoded here and passed to the engine and to the data path.

When the engine reports completion, the block stores the card's response in four 32-bit response words. A short response keeps only its 32 payload bits. A long response is stored right-justified with the CRC byte dropped, so software has to shift it back into place. A completion sets a sticky response-end status bit and a timeout sets a sticky timeout bit. Both are presented as event outputs and are cleared by writing ones. The block can also issue the stop command (opcode 12) on its own. Software can force it at once, or the block issues it after a multi-block transfer when automatic stop is enabled. A stop that is requested while a command is in flight waits until that command ends.

Top module: `sdcmd_front`

## Requirements
- R1: After reset the status register (offset 0x1C) reads 0, every response half reads 0, eng_start is low and the busy bit is clear.
- R2: A write to offset 0x00 with a valid response code pulses eng_start for exactly one cycle. It presents opcode = bits 5:0, argument = {half at 0x06, half at 0x04} and the engine class on eng_rtype (0 none, 1 short, 2 long). Status bit 2 (busy) stays set until the engine reports completion.
- R3: Command word bits 10:8 select the response: 3 gives none, 4, 5 and 7 give short, and 6 gives long. Code 5 also drives eng_busy_wait high. Codes 0 to 2 are ignored: no launch takes place and the command register keeps its old value.
- R4: A command word write while the block is busy is ignored. No launch takes place and offset 0x00 still reads the command in flight.
- R5: On completion of a short-response command, bits 39:8 of the raw 48-bit frame are stored in response word 0 (low half at 0x0C, high half at 0x0E). The other response words are unchanged.
- R6: On completion of a long-response command, raw bits 127:8 are stored right-justified across 0x0C..0x1B, with the least significant half at 0x0C. The top byte of the half at 0x1A reads 0.
- R7: A no-response command sets response-end on completion and leaves all response registers unchanged.
- R8: A timeout sets status bit 1 and evt_timeout. It does not set response-end, and all response registers stay unchanged.
- R9: Status bits 0 (response-end), 1 (timeout) and 3 (stop done) are sticky and are cleared by writing 1 to them at 0x1C. evt_resp_end and evt_timeout follow bits 0 and 1.
- R10: Command word bits 11, 12 and 13 appear on dat_present, dat_read and dat_multi, held from the last accepted command.
- R11: Writing bit 0 at offset 0x08 issues a stop command: opcode 12, argument 0, short response, busy wait. Its completion sets status bit 3 only and does not touch the response registers.
- R12: When bit 8 at 0x08 is set and the last accepted command had the multi-block bit, a xfer_done pulse issues a stop command. Without automatic stop enabled, or after a single-block command, xfer_done issues nothing.
- R13: A stop requested while a command is in flight is deferred and issued once that command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| evt_resp_end | output | 1 | Response-end status level |
| evt_timeout | output | 1 | Command-timeout status level |
| xfer_done | input | 1 | Pulse from the data path at the end of a transfer |
| dat_present | output | 1 | Last accepted command has a data phase |
| dat_read | output | 1 | Data phase is a read |
| dat_multi | output | 1 | Data phase is multi-block |
| eng_start | output | 1 | One-cycle launch pulse to the serial engine |
| eng_index | output | 6 | Command opcode for the engine |
| eng_arg | output | ARG_W | Command argument for the engine |
| eng_rtype | output | 2 | Response class: 0 none, 1 short, 2 long |
| eng_busy_wait | output | 1 | Engine must wait for card busy after the response |
| eng_done | input | 1 | Engine pulse: command shifted out or response received |
| eng_tmo | input | 1 | Engine pulse: no response within the time limit |
| eng_resp | input | RAW_W | Raw response frame, right-aligned, valid with eng_done |

## Verification
The assertions assume a well-behaved engine. It gives at most one eng_done or eng_tmo per launch, never in the same cycle as eng_start, and holds eng_resp steady while eng_done is high. They also assume xfer_done arrives only after a data command has been accepted. The bench engine model replies only after it has seen eng_start, and it drives one completion pulse per command. The bench raises xfer_done only between commands, so every stimulus stays inside those assumptions, while the busy, bad-code and deferred-stop cases still reach the block's rejection and queueing paths.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_SHORT = 2'd1,
      RK_LONG  = 2'd2,
      RK_BAD   = 2'd3
   } rsp_kind_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_CMD  = 2'd1,
      SQ_STOP = 2'd2
   } seq_state_t;

   // register byte offsets
   localparam int unsigned OFS_CMD  = 'h00;
   localparam int unsigned OFS_ARGL = 'h04;
   localparam int unsigned OFS_ARGH = 'h06;
   localparam int unsigned OFS_STOP = 'h08;
   localparam int unsigned OFS_RESP = 'h0C;
   localparam int unsigned OFS_STAT = 'h1C;

   // command word field positions
   localparam int unsigned CW_RCODE_LO = 8;
   localparam int unsigned CW_DATA     = 11;
   localparam int unsigned CW_READ     = 12;
   localparam int unsigned CW_MULTI    = 13;

   localparam logic [5:0] STOP_OPCODE = 6'd12;
   localparam logic [2:0] RCODE_BUSY  = 3'd5;

   function automatic rsp_kind_t decode_kind(input logic [2:0] code);
      case (code)
         3'd3:             return RK_NONE;
         3'd4, 3'd5, 3'd7: return RK_SHORT;
         3'd6:             return RK_LONG;
         default:          return RK_BAD;
      endcase
   endfunction

endpackage

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
   import sdcmd_pkg::*;
#(
   parameter int ARG_W = 32,
   parameter int CW_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CW_W-1:0]  cmd_wdata,
   input  logic [ARG_W-1:0] arg,
   input  logic             stop_force,
   input  logic             auto_en,
   input  logic             xfer_done,
   input  logic             eng_done,
   input  logic             eng_tmo,
   output logic             eng_start,
   output logic [5:0]       eng_index,
   output logic [ARG_W-1:0] eng_arg,
   output logic [1:0]       eng_rtype,
   output logic             eng_busy_wait,
   output logic [CW_W-1:0]  cmd_word,
   output logic             busy,
   output logic             ev_resp_end,
   output logic             ev_tmo,
   output logic             ev_stop_done,
   output logic             cap_short,
   output logic             cap_long
);

   seq_state_t       state_q;
   rsp_kind_t        kind_q, new_kind;
   logic             stop_pend_q, idle, take_cmd, take_stop, auto_hit, finish;
   logic             start_q, bw_q;
   logic [5:0]       index_q;
   logic [ARG_W-1:0] arg_q;
   logic [CW_W-1:0]  cw_q;

   assign new_kind  = decode_kind(cmd_wdata[CW_RCODE_LO +: 3]);
   assign idle      = (state_q == SQ_IDLE);
   assign take_stop = idle & stop_pend_q;
   assign take_cmd  = idle & ~stop_pend_q & cmd_wr & (new_kind != RK_BAD);
   assign auto_hit  = xfer_done & auto_en & cw_q[CW_MULTI];
   assign finish    = ~idle & (eng_done | eng_tmo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         kind_q      <= RK_NONE;
         stop_pend_q <= 1'b0;
         start_q     <= 1'b0;
         bw_q        <= 1'b0;
         index_q     <= '0;
         arg_q       <= '0;
         cw_q        <= '0;
      end else begin
         start_q <= take_cmd | take_stop;
         if (take_cmd) begin
            cw_q    <= cmd_wdata;
            kind_q  <= new_kind;
            index_q <= cmd_wdata[5:0];
            arg_q   <= arg;
            bw_q    <= (cmd_wdata[CW_RCODE_LO +: 3] == RCODE_BUSY);
            state_q <= SQ_CMD;
         end else if (take_stop) begin
            kind_q  <= RK_SHORT;
            index_q <= STOP_OPCODE;
            arg_q   <= '0;
            bw_q    <= 1'b1;
            state_q <= SQ_STOP;
         end else if (finish) begin
            state_q <= SQ_IDLE;
         end
         if (stop_force | auto_hit)
            stop_pend_q <= 1'b1;
         else if (take_stop)
            stop_pend_q <= 1'b0;
      end
   end

   assign eng_start     = start_q;
   assign eng_index     = index_q;
   assign eng_arg       = arg_q;
   assign eng_rtype     = kind_q;
   assign eng_busy_wait = bw_q;
   assign cmd_word      = cw_q;
   assign busy          = ~idle | stop_pend_q;
   assign ev_resp_end   = (state_q == SQ_CMD) & eng_done & ~eng_tmo;
   assign ev_tmo        = finish & eng_tmo;
   assign ev_stop_done  = (state_q == SQ_STOP) & eng_done & ~eng_tmo;
   assign cap_short     = ev_resp_end & (kind_q == RK_SHORT);
   assign cap_long      = ev_resp_end & (kind_q == RK_LONG);

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !idle);

   // R4
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !idle) |=> $stable(cw_q));

   // R13
   stop_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pend_q && idle) |=> (start_q && index_q == STOP_OPCODE));

endmodule

// File: rtl/sdcmd_resp.sv
module sdcmd_resp #(
   parameter int WORD_W = 32,
   parameter int NWORDS = 4,
   parameter int RAW_W  = 136,
   parameter int CRC_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_short,
   input  logic                     cap_long,
   input  logic [RAW_W-1:0]         raw,
   output logic [NWORDS*WORD_W-1:0] flat
);

   localparam int IMG_W  = NWORDS * WORD_W;
   localparam int KEEP_W = RAW_W - 2 * CRC_W;

   logic [IMG_W-1:0] long_img;
   logic             unused_top;

   assign long_img   = IMG_W'(raw[RAW_W-CRC_W-1:CRC_W]);
   assign unused_top = ^raw[RAW_W-1 -: CRC_W];

   if (RAW_W != IMG_W + CRC_W) begin : g_bad_raw
      $error("sdcmd_resp: RAW_W must equal NWORDS*WORD_W + CRC_W");
   end
   if (KEEP_W <= WORD_W) begin : g_bad_keep
      $error("sdcmd_resp: long frame too narrow");
   end

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      logic [WORD_W-1:0] w_q;
      if (i == 0) begin : g_short_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         w_q <= '0;
            else if (cap_long)  w_q <= long_img[i*WORD_W +: WORD_W];
            else if (cap_short) w_q <= raw[CRC_W +: WORD_W];
         end
      end else begin : g_long_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        w_q <= '0;
            else if (cap_long) w_q <= long_img[i*WORD_W +: WORD_W];
         end
      end
      assign flat[i*WORD_W +: WORD_W] = w_q;
   end

   // R6
   long_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_long |=> (flat[IMG_W-1 -: CRC_W] == '0));

   // R5
   short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_short && !cap_long) |=> $stable(flat[IMG_W-1:WORD_W]));

endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
   import sdcmd_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int ARG_W  = 32,
   parameter int RSP_B  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [RSP_B-1:0] resp_flat,
   input  logic [DW-1:0]    cmd_word,
   input  logic             busy,
   input  logic             ev_resp_end,
   input  logic             ev_tmo,
   input  logic             ev_stop_done,
   output logic [ARG_W-1:0] arg,
   output logic             auto_en,
   output logic             stop_force,
   output logic             cmd_wr,
   output logic             st_resp_end,
   output logic             st_tmo
);

   localparam int NHALF = RSP_B / DW;

   logic [DW-1:0] argl_q, argh_q;
   logic          auto_q, re_q, to_q, sd_q;
   logic          hit_argl, hit_argh, hit_stop, hit_stat;

   assign hit_argl   = wr & (addr == AW'(OFS_ARGL));
   assign hit_argh   = wr & (addr == AW'(OFS_ARGH));
   assign hit_stop   = wr & (addr == AW'(OFS_STOP));
   assign hit_stat   = wr & (addr == AW'(OFS_STAT));
   assign cmd_wr     = wr & (addr == AW'(OFS_CMD));
   assign stop_force = hit_stop & wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         argl_q <= '0;
         argh_q <= '0;
         auto_q <= 1'b0;
         re_q   <= 1'b0;
         to_q   <= 1'b0;
         sd_q   <= 1'b0;
      end else begin
         if (hit_argl) argl_q <= wdata;
         if (hit_argh) argh_q <= wdata;
         if (hit_stop) auto_q <= wdata[8];
         if (ev_resp_end)                re_q <= 1'b1;
         else if (hit_stat && wdata[0])  re_q <= 1'b0;
         if (ev_tmo)                     to_q <= 1'b1;
         else if (hit_stat && wdata[1])  to_q <= 1'b0;
         if (ev_stop_done)               sd_q <= 1'b1;
         else if (hit_stat && wdata[3])  sd_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(OFS_CMD))  rdata = cmd_word;
      if (addr == AW'(OFS_ARGL)) rdata = argl_q;
      if (addr == AW'(OFS_ARGH)) rdata = argh_q;
      if (addr == AW'(OFS_STOP)) rdata = DW'({auto_q, 8'h00});
      if (addr == AW'(OFS_STAT)) rdata = DW'({sd_q, busy, to_q, re_q});
      for (int k = 0; k < NHALF; k++) begin
         if (addr == AW'(OFS_RESP + 2 * k)) rdata = resp_flat[k*DW +: DW];
      end
   end

   assign arg         = ARG_W'({argh_q, argl_q});
   assign auto_en     = auto_q;
   assign st_resp_end = re_q;
   assign st_tmo      = to_q;

   // R9
   clear_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat && wdata[0] && !ev_resp_end) |=> !re_q);

   // R9
   sticky_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (to_q && !(hit_stat && wdata[1])) |=> to_q);

endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
   import sdcmd_pkg::*;
#(
   parameter int AW     = 8,
   parameter int ARG_W  = 32,
   parameter int WORD_W = 32,
   parameter int NWORDS = 4,
   parameter int CRC_W  = 8,
   parameter int RAW_W  = NWORDS * WORD_W + CRC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   output logic             evt_resp_end,
   output logic             evt_timeout,
   input  logic             xfer_done,
   output logic             dat_present,
   output logic             dat_read,
   output logic             dat_multi,
   output logic             eng_start,
   output logic [5:0]       eng_index,
   output logic [ARG_W-1:0] eng_arg,
   output logic [1:0]       eng_rtype,
   output logic             eng_busy_wait,
   input  logic             eng_done,
   input  logic             eng_tmo,
   input  logic [RAW_W-1:0] eng_resp
);

   localparam int DW    = 16;
   localparam int RSP_B = NWORDS * WORD_W;

   if (ARG_W != 2 * DW) begin : g_bad_arg
      $error("sdcmd_front: argument must be two register halves");
   end
   if (AW < 5) begin : g_bad_aw
      $error("sdcmd_front: address too narrow for register map");
   end

   logic [ARG_W-1:0] arg;
   logic [DW-1:0]    cmd_word;
   logic [RSP_B-1:0] resp_flat;
   logic auto_en, stop_force, cmd_wr, busy;
   logic ev_resp_end, ev_tmo, ev_stop_done, cap_short, cap_long;

   sdcmd_regs #(.AW(AW), .DW(DW), .ARG_W(ARG_W), .RSP_B(RSP_B)) u_regs (
      .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .resp_flat, .cmd_word, .busy, .ev_resp_end,
      .ev_tmo, .ev_stop_done, .arg, .auto_en, .stop_force, .cmd_wr,
      .st_resp_end(evt_resp_end), .st_tmo(evt_timeout)
   );

   sdcmd_seq #(.ARG_W(ARG_W), .CW_W(DW)) u_seq (
      .clk, .rst_n, .cmd_wr, .cmd_wdata(reg_wdata), .arg, .stop_force,
      .auto_en, .xfer_done, .eng_done, .eng_tmo, .eng_start, .eng_index,
      .eng_arg, .eng_rtype, .eng_busy_wait, .cmd_word, .busy, .ev_resp_end,
      .ev_tmo, .ev_stop_done, .cap_short, .cap_long
   );

   sdcmd_resp #(.WORD_W(WORD_W), .NWORDS(NWORDS), .RAW_W(RAW_W), .CRC_W(CRC_W)) u_resp (
      .clk, .rst_n, .cap_short, .cap_long, .raw(eng_resp), .flat(resp_flat)
   );

   assign dat_present = cmd_word[CW_DATA];
   assign dat_read    = cmd_word[CW_READ];
   assign dat_multi   = cmd_word[CW_MULTI];

   // R8
   tmo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tmo |=> $stable(resp_flat));

   // R7
   none_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !eng_tmo && eng_rtype == 2'd0) |=> $stable(resp_flat));

   // R8
   tmo_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_tmo && !(reg_wr && reg_addr == AW'(OFS_STAT))) |=> evt_timeout);

endmodule

// File: tb/sim_sdcmd_front.sv
module sim_sdcmd_front;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [15:0]  reg_wdata = '0;
   logic [15:0]  reg_rdata;
   logic         evt_resp_end, evt_timeout;
   logic         xfer_done = 1'b0;
   logic         dat_present, dat_read, dat_multi;
   logic         eng_start;
   logic [5:0]   eng_index;
   logic [31:0]  eng_arg;
   logic [1:0]   eng_rtype;
   logic         eng_busy_wait;
   logic         eng_done = 1'b0;
   logic         eng_tmo = 1'b0;
   logic [135:0] eng_resp = '0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   localparam logic [119:0] PAT = 120'h0123456789ABCDEF_FEDCBA98765432;
   localparam logic [127:0] LONG_EXP = {8'h00, PAT};

   always #10 clk = ~clk;

   sdcmd_front u0 (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .evt_resp_end, .evt_timeout, .xfer_done, .dat_present, .dat_read,
      .dat_multi, .eng_start, .eng_index, .eng_arg, .eng_rtype,
      .eng_busy_wait, .eng_done, .eng_tmo, .eng_resp
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_start(output bit seen);
      seen = 0;
      for (int i = 0; i < 6; i++) begin
         if (eng_start) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic no_start(input string tag, input int n);
      bit any = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (eng_start) any = 1;
      end
      chk(tag, 32'(any), 32'd0);
   endtask

   task automatic reply(input bit tmo, input logic [135:0] raw);
      @(negedge clk);
      eng_done = ~tmo; eng_tmo = tmo; eng_resp = raw;
      @(negedge clk);
      eng_done = 1'b0; eng_tmo = 1'b0;
   endtask

   task automatic pulse_xfer();
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(8'h1C, v); chk("R1 status", 32'(v), 32'h0);
      for (int k = 0; k < 8; k++) begin
         rd(8'(8'h0C + 2 * k), v); chk("R1 resp half", 32'(v), 32'h0);
      end
      chk("R1 eng_start", 32'(eng_start), 32'd0);
   endtask

   task automatic t_short();
      logic [15:0] v; bit s;
      wr(8'h04, 16'h5678); wr(8'h06, 16'h1234);
      wr(8'h00, 16'h1C11);
      wait_start(s); chk("R2 launch", 32'(s), 32'd1);
      chk("R2 index", 32'(eng_index), 32'd17);
      chk("R2 arg", eng_arg, 32'h12345678);
      chk("R3 short class", 32'(eng_rtype), 32'd1);
      chk("R3 no busy wait", 32'(eng_busy_wait), 32'd0);
      @(negedge clk);
      chk("R2 single pulse", 32'(eng_start), 32'd0);
      chk("R10 flags", 32'({dat_present, dat_read, dat_multi}), 32'b110);
      rd(8'h1C, v); chk("R2 busy bit", 32'(v), 32'h4);
      reply(0, 136'(48'h11_CAFEF00D_AB));
      rd(8'h0C, v); chk("R5 low half", 32'(v), 32'hF00D);
      rd(8'h0E, v); chk("R5 high half", 32'(v), 32'hCAFE);
      rd(8'h1C, v); chk("R9 resp end", 32'(v), 32'h1);
      chk("R9 evt_resp_end", 32'(evt_resp_end), 32'd1);
      wr(8'h1C, 16'h0001);
      rd(8'h1C, v); chk("R9 w1c", 32'(v), 32'h0);
      chk("R9 evt cleared", 32'(evt_resp_end), 32'd0);
   endtask

   task automatic t_long();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0602);
      wait_start(s); chk("R6 launch", 32'(s), 32'd1);
      chk("R3 long class", 32'(eng_rtype), 32'd2);
      reply(0, {8'h3F, PAT, 8'hA5});
      for (int k = 0; k < 8; k++) begin
         rd(8'(8'h0C + 2 * k), v);
         chk("R6 long half", 32'(v), 32'(LONG_EXP[k*16 +: 16]));
      end
      wr(8'h1C, 16'h0001);
   endtask

   task automatic t_none();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0300);
      wait_start(s); chk("R7 launch", 32'(s), 32'd1);
      chk("R3 none class", 32'(eng_rtype), 32'd0);
      reply(0, '1);
      rd(8'h1C, v); chk("R7 resp end", 32'(v), 32'h1);
      rd(8'h0C, v); chk("R7 keep low", 32'(v), 32'(LONG_EXP[15:0]));
      rd(8'h1A, v); chk("R7 keep top", 32'(v), 32'(LONG_EXP[127:112]));
      wr(8'h1C, 16'h0001);
   endtask

   task automatic t_tmo();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0408);
      wait_start(s); chk("R8 launch", 32'(s), 32'd1);
      reply(1, '1);
      rd(8'h1C, v); chk("R8 status", 32'(v), 32'h2);
      chk("R8 evt_timeout", 32'(evt_timeout), 32'd1);
      chk("R8 no resp end", 32'(evt_resp_end), 32'd0);
      rd(8'h0E, v); chk("R8 keep", 32'(v), 32'(LONG_EXP[31:16]));
      wr(8'h1C, 16'h0002);
      chk("R9 timeout cleared", 32'(evt_timeout), 32'd0);
   endtask

   task automatic t_busy();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0405);
      wait_start(s); chk("R4 first launch", 32'(s), 32'd1);
      wr(8'h00, 16'h0409);
      chk("R4 no relaunch now", 32'(eng_start), 32'd0);
      no_start("R4 no relaunch", 3);
      rd(8'h00, v); chk("R4 cmd kept", 32'(v), 32'h0405);
      reply(0, '0);
      wr(8'h1C, 16'h0001);
   endtask

   task automatic t_codes();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0107);
      chk("R3 bad code now", 32'(eng_start), 32'd0);
      no_start("R3 bad code", 3);
      rd(8'h00, v); chk("R3 bad code kept", 32'(v), 32'h0405);
      rd(8'h1C, v); chk("R3 not busy", 32'(v), 32'h0);
      wr(8'h00, 16'h0507);
      wait_start(s); chk("R3 code5 launch", 32'(s), 32'd1);
      chk("R3 code5 busy wait", 32'(eng_busy_wait), 32'd1);
      chk("R3 code5 short", 32'(eng_rtype), 32'd1);
      reply(0, '0);
      wr(8'h00, 16'h0729);
      wait_start(s); chk("R3 code7 short", 32'(eng_rtype), 32'd1);
      reply(0, 136'(48'h29_00000ABC_01));
      rd(8'h0C, v); chk("R5 code7 stored", 32'(v), 32'h0ABC);
      rd(8'h10, v); chk("R5 word1 kept", 32'(v), 32'(LONG_EXP[47:32]));
      wr(8'h1C, 16'h0001);
   endtask

   task automatic t_force();
      logic [15:0] v; bit s;
      wr(8'h08, 16'h0001);
      wait_start(s); chk("R11 launch", 32'(s), 32'd1);
      chk("R11 index", 32'(eng_index), 32'd12);
      chk("R11 arg", eng_arg, 32'h0);
      chk("R11 busy wait", 32'(eng_busy_wait), 32'd1);
      reply(0, 136'(48'h0C_DEADBEEF_11));
      rd(8'h1C, v); chk("R11 status", 32'(v), 32'h8);
      rd(8'h0C, v); chk("R11 resp kept", 32'(v), 32'h0ABC);
      wr(8'h1C, 16'h0008);
   endtask

   task automatic t_auto();
      logic [15:0] v; bit s;
      wr(8'h08, 16'h0100);
      rd(8'h08, v); chk("R12 enable readback", 32'(v), 32'h0100);
      wr(8'h00, 16'h3C12);
      wait_start(s);
      chk("R10 multi", 32'(dat_multi), 32'd1);
      reply(0, '0);
      wr(8'h1C, 16'h0001);
      pulse_xfer();
      wait_start(s); chk("R12 auto stop", 32'(s), 32'd1);
      chk("R12 index", 32'(eng_index), 32'd12);
      reply(0, '0);
      rd(8'h1C, v); chk("R12 stop done", 32'(v), 32'h8);
      wr(8'h1C, 16'h0008);
      wr(8'h00, 16'h1C11);
      wait_start(s); reply(0, '0); wr(8'h1C, 16'h0001);
      pulse_xfer();
      no_start("R12 single block", 4);
      wr(8'h08, 16'h0000);
      wr(8'h00, 16'h3C12);
      wait_start(s); reply(0, '0); wr(8'h1C, 16'h0001);
      pulse_xfer();
      no_start("R12 disabled", 4);
   endtask

   task automatic t_defer();
      logic [15:0] v; bit s;
      wr(8'h00, 16'h0405);
      wait_start(s);
      wr(8'h08, 16'h0001);
      no_start("R13 deferred", 3);
      rd(8'h1C, v); chk("R13 busy", 32'(v), 32'h4);
      reply(0, '0);
      wait_start(s); chk("R13 stop issued", 32'(s), 32'd1);
      chk("R13 index", 32'(eng_index), 32'd12);
      reply(0, '0);
      rd(8'h1C, v); chk("R13 status", 32'(v), 32'h9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_short();
      t_long();
      t_none();
      t_tmo();
      t_busy();
      t_codes();
      t_force();
      t_auto();
      t_defer();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule